// File: doc/BRIEF.md
# Clock and Power Control Register

This block is one 32-bit control register inside a reset, clock and power controller. Software reaches it over a zero-wait-state APB slave port. The register holds three settings. The first is a global write-lock bit, which guards this register's other fields and is also sent out so that every sibling register in the controller can gate its own writes. The second is a two-bit selector that routes one of three clocks, or a constant low, to an external clock-out pin. The third is a power-mode request field.

When software writes a defined low-power mode code, the block raises a request toward the power sequencer and carries the 3-bit code with it. The request stays up until the sequencer pulses a wakeup input. The mode field never reads back: it always returns zero. The low two bits always read as ones. All other unused bits read as zeros.

Top module: `clkpwr_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x0000_0263, `mode_req` is 0, `mode_code` is 0 and `sib_wr_en` is 1.
- R2: Bits 31:10, 8 and 7 always read 0. Bits 1:0 always read 1. Writes to any of these bits have no effect on the value read back.
- R3: Bits 6:5 store the clock-out select, and it reads back. Code 00 routes `osc_clk`, 01 drives `clk_out` low, 10 routes `fclk` and 11 routes `hclk`.
- R4: Bits 4:2, the mode field, always read as 000.
- R5: A write whose bits 4:2 hold 001 (Standby), 010 (Sleep), 011 (Stop1) or 100 (Stop2) sets `mode_req` to 1 and `mode_code` to that code on the access-phase clock edge. The request then holds until a wakeup. A write of 000 leaves any pending request and its code unchanged.
- R6: A one-cycle `wake` pulse clears `mode_req` and `mode_code` to 0. If a valid mode write lands in the same cycle as the pulse, the write wins.
- R7: A write of mode code 101, 110 or 111 is treated as Active. It raises no request and leaves any pending request unchanged.
- R8: Bit 9 is the lock bit, and 1 means writes are enabled. While the lock bit is 0, writes do not change the clock-out select or the mode request, but bit 9 itself can still be written.
- R9: `sib_wr_en` always equals the lock bit. Sibling registers AND it into their write strobe.
- R10: An access whose `paddr` differs from `REG_ADDR` reads 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| wake | input | 1 | Wakeup pulse from the power sequencer |
| mode_req | output | 1 | Pending power-mode request |
| mode_code | output | 3 | Requested mode code |
| sib_wr_en | output | 1 | Write qualifier for sibling registers |
| osc_clk | input | 1 | System oscillator clock |
| fclk | input | 1 | Core clock |
| hclk | input | 1 | Bus clock source |
| clk_out | output | 1 | Selected clock-out |

## Verification
Random write data is sent to the register with the mode bits biased toward defined, undefined and zero codes. These writes are mixed with wake pulses, so they tell a real request apart from an Active-equivalent code and show that an idle write does not cancel a pending request. Random lock states cover both the locked and the unlocked case. Writes to other addresses show that decoding is tied to one address. Each check drives random levels on the three clock sources and sweeps all four selects, so a swapped mux leg shows up. Directed cases cover the reset value, an all-ones write, and a wake pulse that lands in the same cycle as a mode write.

// File: rtl/clkpwr_ctrl_reg.sv
module clkpwr_ctrl_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              wake,
  output logic              mode_req,
  output logic [2:0]        mode_code,
  output logic              sib_wr_en,
  input  logic              osc_clk,
  input  logic              fclk,
  input  logic              hclk,
  output logic              clk_out
);

  logic       lock_q;
  logic [1:0] sel_q;
  logic       req_q;
  logic [2:0] code_q;

  wire       hit     = psel && (paddr == REG_ADDR);
  wire       wr      = hit && penable && pwrite;
  wire [2:0] wr_mode = pwdata[4:2];
  wire       mode_ok = (wr_mode != 3'd0) && (wr_mode <= 3'd4);
  wire       wr_req  = wr && lock_q && mode_ok;
  wire       unused_bits = ^{pwdata[31:10], pwdata[8:7], pwdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      sel_q  <= 2'b11;
      req_q  <= 1'b0;
      code_q <= 3'd0;
    end else begin
      if (wr) lock_q <= pwdata[9];
      if (wr && lock_q) sel_q <= pwdata[6:5];
      if (wr_req) begin
        req_q  <= 1'b1;
        code_q <= wr_mode;
      end else if (wake) begin
        req_q  <= 1'b0;
        code_q <= 3'd0;
      end
    end
  end

  assign prdata    = hit ? {22'd0, lock_q, 2'b00, sel_q, 3'b000, 2'b11} : 32'd0;
  assign mode_req  = req_q;
  assign mode_code = code_q;
  assign sib_wr_en = lock_q;

  always_comb begin
    case (sel_q)
      2'b00:   clk_out = osc_clk;
      2'b01:   clk_out = 1'b0;
      2'b10:   clk_out = fclk;
      default: clk_out = hclk;
    endcase
  end

  // R8
  blocked_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sib_wr_en) |=> $stable(sel_q));

  // R8
  blocked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sib_wr_en && !mode_req) |=> !mode_req);

  // R6
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !wr_req) |=> (!mode_req && mode_code == 3'd0));

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_mode > 3'd4 && !mode_req && !wake) |=> !mode_req);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && !wake) |=> mode_req);

  // R5
  req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (mode_req && mode_code == $past(wr_mode)));

endmodule

// File: tb/clkpwr_ctrl_reg_tb.sv
module clkpwr_ctrl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        wake = 1'b0;
  logic        mode_req, sib_wr_en, clk_out;
  logic [2:0]  mode_code;
  logic        osc_clk = 1'b0, fclk = 1'b0, hclk = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic       m_lock = 1'b1;
  logic [1:0] m_sel = 2'b11;
  logic       m_req = 1'b0;
  logic [2:0] m_code = 3'd0;

  always #2 clk = ~clk;

  clkpwr_ctrl_reg #(.ADDR_W(8), .REG_ADDR(8'h00)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .wake(wake),
    .mode_req(mode_req), .mode_code(mode_code), .sib_wr_en(sib_wr_en),
    .osc_clk(osc_clk), .fclk(fclk), .hclk(hclk), .clk_out(clk_out));

  function automatic logic [31:0] exp_read();
    return {22'd0, m_lock, 2'b00, m_sel, 3'b000, 2'b11};
  endfunction

  function automatic logic exp_clk(logic [1:0] s, logic o, logic f, logic h);
    case (s)
      2'b00: return o;
      2'b01: return 1'b0;
      2'b10: return f;
      default: return h;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    if (a != 8'h00) return;
    if (m_lock) begin
      m_sel = d[6:5];
      if (d[4:2] != 3'd0 && d[4:2] <= 3'd4) begin
        m_req = 1'b1;
        m_code = d[4:2];
      end
    end
    m_lock = d[9];
  endtask

  task automatic apb_write(logic [7:0] a, logic [31:0] d, bit with_wake);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1; wake = with_wake;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; wake = 1'b0;
    if (with_wake) begin m_req = 1'b0; m_code = 3'd0; end
    model_write(a, d);
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    m_req = 1'b0; m_code = 3'd0;
  endtask

  task automatic check_all(string ctx);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 8'h00;
    #1;
    chk({ctx, " R2 R4 R8 read"}, prdata, exp_read());
    chk({ctx, " R5 R6 R7 req"}, {31'd0, mode_req}, {31'd0, m_req});
    chk({ctx, " R5 code"}, {29'd0, mode_code}, {29'd0, m_code});
    chk({ctx, " R9 sib_wr_en"}, {31'd0, sib_wr_en}, {31'd0, m_lock});
    paddr = 8'h04 + 8'($urandom_range(0, 200));
    #1;
    chk({ctx, " R10 other addr read"}, prdata, 32'd0);
    psel = 1'b0;
    for (int k = 0; k < 3; k++) begin
      osc_clk = 1'($urandom); fclk = 1'($urandom); hclk = 1'($urandom);
      #1;
      chk({ctx, " R3 clk_out"}, {31'd0, clk_out},
          {31'd0, exp_clk(m_sel, osc_clk, fclk, hclk)});
    end
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] d = $urandom;
    int r = $urandom_range(0, 9);
    if (r < 4) d[4:2] = 3'($urandom_range(1, 4));
    else if (r < 6) d[4:2] = 3'($urandom_range(5, 7));
    else if (r < 8) d[4:2] = 3'd0;
    if ($urandom_range(0, 3) != 0) d[9] = 1'b1;
    return d;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    psel = 1'b1; paddr = 8'h00; #1;
    chk("R1 reset value", prdata, 32'h0000_0263);
    chk("R1 reset req", {28'd0, mode_req, mode_code}, 32'd0);
    chk("R1 reset sib_wr_en", {31'd0, sib_wr_en}, 32'd1);
    psel = 1'b0;
    check_all("reset");

    apb_write(8'h00, 32'hFFFF_FFFF, 0); check_all("R2 all ones");
    apb_write(8'h00, 32'h0000_0220, 0); check_all("R3 sel 01");
    apb_write(8'h00, 32'h0000_0208, 0); check_all("R5 sleep");
    apb_write(8'h00, 32'h0000_0200, 0); check_all("R5 zero keeps");
    pulse_wake();                        check_all("R6 wake");
    apb_write(8'h00, 32'h0000_0214, 0); check_all("R7 code 101");
    apb_write(8'h00, 32'h0000_0210, 0);
    apb_write(8'h00, 32'h0000_020C, 1); check_all("R6 write wins");
    pulse_wake();
    apb_write(8'h00, 32'h0000_0000, 0); check_all("R8 lock clear");
    apb_write(8'h00, 32'h0000_0044, 0); check_all("R8 blocked");
    apb_write(8'h40, 32'h0000_0244, 0); check_all("R10 other addr");
    apb_write(8'h00, 32'h0000_0200, 0); check_all("R8 unlock");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 6)      apb_write(8'h00, rand_word(), 0);
      else if (op < 7) apb_write(8'($urandom_range(1, 255)), rand_word(), 0);
      else if (op < 8) apb_write(8'h00, rand_word(), 1);
      else             pulse_wake();
      check_all("random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule